// File: doc/BRIEF.md
# Time-Aware Egress Gate Scheduler

This block drives the eight transmission gates of one egress port from a cyclic gate control list. Each list entry holds an 8-bit open mask, where bit n belongs to traffic class n, and a duration in nanoseconds. A free-running nanosecond time input, kept in step with the network clock outside this block, is compared against internally kept deadlines. Once the programmed start time is reached, the block walks the list in order and restarts it at entry 0 every cycle period.

Every gate event is placed on a 200 ns slot grid. The start time, the cycle period and every entry duration are rounded up to whole slots. A neighbouring scheduler reports through a busy-slot input that it owns the current slot. If this block fires an event in that same slot, it flags a conflict in the same cycle as its event strobe. The list, start time, cycle period and list length are loaded while the schedule is disabled and are frozen while it runs.

Top module: `tas_gate_sched`

## Requirements
- R1: Bit n of the active entry's mask drives `gate_open_o[n]`. Entries are applied in index order 0, 1, … up to list length minus one.
- R2: While the schedule is enabled and the time input is below the start time, all gates stay closed. The start time is rounded up to a multiple of 200 ns. Entry 0 opens in the first cycle whose sampled time is at or past that rounded start.
- R3: An entry duration that is not a multiple of 200 ns is rounded up to the next multiple. A duration of 0 counts as 200 ns.
- R4: The cycle period is rounded up to whole 200 ns slots. At start plus each whole period, the schedule returns to entry 0 even if a later entry has not used up its duration. The last entry holds until the period ends.
- R5: `gate_event_o` is high for exactly one clock in the cycle whose outputs show a newly started entry, including the first start and each wrap. It is low otherwise.
- R6: `conflict_o` is high in the same cycle as `gate_event_o` when `peer_slot_busy` was high at the clock edge that fired the event. It is never high without an event.
- R7: List writes, and changes to the start time, cycle period and list length inputs, have no effect while `sched_en` is high.
- R8: When `sched_en` is low, all gates close and the event strobe is low from the next clock. Enabling again restarts from entry 0 at the newly captured start time.
- R9: After reset, the gates are closed, the event and conflict outputs are low, and the entry index is 0.
- R10: `entry_idx_o` shows the index of the entry whose mask is on the gates. It is always below the list length while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ns | input | 64 | Free-running synchronized time in ns |
| sched_en | input | 1 | Schedule enable; configuration is captured while low |
| start_ns | input | 64 | Schedule start time in ns |
| period_ns | input | 32 | Cycle period in ns |
| list_len | input | 5 | Number of active entries (1 to 16) |
| wr_en | input | 1 | List entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_mask | input | 8 | Gate-open mask to write |
| wr_dur_ns | input | 32 | Entry duration in ns to write |
| peer_slot_busy | input | 1 | Another scheduler owns the current slot |
| gate_open_o | output | 8 | Gate-open vector, bit n = traffic class n |
| gate_event_o | output | 1 | One-cycle strobe on each gate event |
| entry_idx_o | output | 4 | Index of the active entry |
| conflict_o | output | 1 | Own event fell in a busy slot |

## Verification
The bench builds the block with its default parameters: 16 entries, 8 classes, 64-bit time, 32-bit durations and a 200 ns slot. It drives the time input directly rather than from simulated time. This lets it step onto the exact nanosecond of each slot boundary and onto the value just before it, so the rounding of the start time, a zero duration, an odd duration and a period shorter than the sum of the entries can all be observed at the edge where they matter. It also places the busy-slot input on event and non-event edges, and it writes the list and the configuration while the schedule runs.

// File: rtl/tas_gate_pkg.sv
package tas_gate_pkg;

    localparam int unsigned SLOT_NS_DEFAULT = 200;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // Round a nanosecond quantity up to the slot grid.
    // keep_zero = 0 turns a zero value into one full slot.
    function automatic logic [63:0] slot_ceil(input logic [63:0] v,
                                              input logic [63:0] slot,
                                              input logic        keep_zero);
        logic [63:0] rem;
        rem = v % slot;
        if (v == 64'd0)
            return keep_zero ? 64'd0 : slot;
        else if (rem == 64'd0)
            return v;
        else
            return v + (slot - rem);
    endfunction

endpackage

// File: rtl/tas_list_store.sv
module tas_list_store
    import tas_gate_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned N_TC      = 8,
    parameter int unsigned TIME_W    = 64,
    parameter int unsigned DUR_W     = 32,
    parameter int unsigned SLOT_NS   = SLOT_NS_DEFAULT,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
    localparam int unsigned LEN_W    = $clog2(N_ENTRIES + 1),
    localparam int unsigned RDUR_W   = DUR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sched_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [N_TC-1:0]   wr_mask,
    input  logic [DUR_W-1:0]  wr_dur_ns,
    input  logic [TIME_W-1:0] start_in,
    input  logic [DUR_W-1:0]  period_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [N_TC-1:0]   rd_mask,
    output logic [RDUR_W-1:0] rd_dur,
    output logic [TIME_W-1:0] start_q,
    output logic [RDUR_W-1:0] period_q,
    output logic [LEN_W-1:0]  len_q
);

    logic [N_ENTRIES-1:0][N_TC-1:0]   mask_q;
    logic [N_ENTRIES-1:0][RDUR_W-1:0] dur_q;
    logic [RDUR_W-1:0]                wr_dur_rnd;
    logic                             wr_ok;

    assign wr_ok      = wr_en && !sched_en;
    assign wr_dur_rnd = RDUR_W'(slot_ceil(64'(wr_dur_ns), 64'(SLOT_NS), 1'b0));

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g] <= '0;
                dur_q[g]  <= RDUR_W'(SLOT_NS);
            end else if (wr_ok && (wr_idx == IDX_W'(g))) begin
                mask_q[g] <= wr_mask;
                dur_q[g]  <= wr_dur_rnd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            period_q <= RDUR_W'(SLOT_NS);
            len_q    <= LEN_W'(1);
        end else if (!sched_en) begin
            start_q  <= TIME_W'(slot_ceil(64'(start_in), 64'(SLOT_NS), 1'b1));
            period_q <= RDUR_W'(slot_ceil(64'(period_in), 64'(SLOT_NS), 1'b0));
            if (len_in == '0)
                len_q <= LEN_W'(1);
            else if (len_in > LEN_W'(N_ENTRIES))
                len_q <= LEN_W'(N_ENTRIES);
            else
                len_q <= len_in;
        end
    end

    assign rd_mask = mask_q[rd_idx];
    assign rd_dur  = dur_q[rd_idx];

    // R7: the list is frozen while the schedule runs
    assert_list_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        sched_en |=> ($stable(mask_q) && $stable(dur_q)));

    // R7: configuration is frozen while the schedule runs
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        sched_en |=> ($stable(start_q) && $stable(period_q) && $stable(len_q)));

endmodule

// File: rtl/tas_sequencer.sv
module tas_sequencer
    import tas_gate_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned N_TC      = 8,
    parameter int unsigned TIME_W    = 64,
    parameter int unsigned DUR_W     = 32,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
    localparam int unsigned LEN_W    = $clog2(N_ENTRIES + 1),
    localparam int unsigned RDUR_W   = DUR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sched_en,
    input  logic [TIME_W-1:0] now_ns,
    input  logic [TIME_W-1:0] start_q,
    input  logic [RDUR_W-1:0] period_q,
    input  logic [LEN_W-1:0]  len_q,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [N_TC-1:0]   rd_mask,
    input  logic [RDUR_W-1:0] rd_dur,
    output logic              fire,
    output logic [N_TC-1:0]   gates_q,
    output logic              event_q,
    output logic [IDX_W-1:0]  idx_q
);

    phase_e            phase_q;
    logic [TIME_W-1:0] entry_dl_q;
    logic [TIME_W-1:0] cycle_dl_q;
    logic [IDX_W-1:0]  tgt_idx;
    logic [TIME_W-1:0] ev_time;
    logic              more_left;

    assign more_left = (LEN_W'(idx_q) + LEN_W'(1)) < len_q;

    always_comb begin
        fire    = 1'b0;
        tgt_idx = '0;
        ev_time = start_q;
        if (sched_en) begin
            if (phase_q != PH_RUN) begin
                if (now_ns >= start_q)
                    fire = 1'b1;
            end else if (now_ns >= cycle_dl_q) begin
                fire    = 1'b1;
                ev_time = cycle_dl_q;
            end else if ((now_ns >= entry_dl_q) && more_left) begin
                fire    = 1'b1;
                tgt_idx = idx_q + IDX_W'(1);
                ev_time = entry_dl_q;
            end
        end
    end

    assign rd_idx = tgt_idx;

    always_ff @(posedge clk) begin
        if (rst || !sched_en) begin
            phase_q    <= PH_OFF;
            idx_q      <= '0;
            gates_q    <= '0;
            event_q    <= 1'b0;
            entry_dl_q <= '0;
            cycle_dl_q <= '0;
        end else begin
            event_q <= fire;
            if (fire) begin
                phase_q    <= PH_RUN;
                idx_q      <= tgt_idx;
                gates_q    <= rd_mask;
                entry_dl_q <= ev_time + TIME_W'(rd_dur);
                if (tgt_idx == '0)
                    cycle_dl_q <= ev_time + TIME_W'(period_q);
            end else if (phase_q == PH_OFF) begin
                phase_q <= PH_ARMED;
            end
        end
    end

    // R2: nothing opens before the start time
    assert_closed_before_start_R2: assert property (@(posedge clk) disable iff (rst)
        (sched_en && (phase_q != PH_RUN) && (now_ns < start_q)) |=> (gates_q == '0));

    // R10: index stays inside the programmed list
    assert_idx_in_list_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN) |-> (LEN_W'(idx_q) < len_q));

    // R4: reaching the period boundary returns to entry 0 with an event
    assert_wrap_to_first_R4: assert property (@(posedge clk) disable iff (rst)
        (sched_en && (phase_q == PH_RUN) && (now_ns >= cycle_dl_q))
            |=> ((idx_q == '0) && event_q));

endmodule

// File: rtl/tas_slot_guard.sv
module tas_slot_guard (
    input  logic clk,
    input  logic rst,
    input  logic sched_en,
    input  logic fire,
    input  logic peer_slot_busy,
    output logic conflict_q
);

    always_ff @(posedge clk) begin
        if (rst || !sched_en)
            conflict_q <= 1'b0;
        else
            conflict_q <= fire && peer_slot_busy;
    end

    // R6: a busy slot without an own event never flags
    assert_quiet_without_event_R6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !conflict_q);

endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
    import tas_gate_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 16,
    parameter int unsigned N_TC      = 8,
    parameter int unsigned TIME_W    = 64,
    parameter int unsigned DUR_W     = 32,
    parameter int unsigned SLOT_NS   = SLOT_NS_DEFAULT,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES),
    localparam int unsigned LEN_W    = $clog2(N_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIME_W-1:0] now_ns,
    input  logic              sched_en,
    input  logic [TIME_W-1:0] start_ns,
    input  logic [DUR_W-1:0]  period_ns,
    input  logic [LEN_W-1:0]  list_len,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [N_TC-1:0]   wr_mask,
    input  logic [DUR_W-1:0]  wr_dur_ns,
    input  logic              peer_slot_busy,
    output logic [N_TC-1:0]   gate_open_o,
    output logic              gate_event_o,
    output logic [IDX_W-1:0]  entry_idx_o,
    output logic              conflict_o
);

    localparam int unsigned RDUR_W = DUR_W + 1;

    logic [IDX_W-1:0]  rd_idx;
    logic [N_TC-1:0]   rd_mask;
    logic [RDUR_W-1:0] rd_dur;
    logic [TIME_W-1:0] start_q;
    logic [RDUR_W-1:0] period_q;
    logic [LEN_W-1:0]  len_q;
    logic              fire;

    tas_list_store #(
        .N_ENTRIES (N_ENTRIES),
        .N_TC      (N_TC),
        .TIME_W    (TIME_W),
        .DUR_W     (DUR_W),
        .SLOT_NS   (SLOT_NS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .sched_en  (sched_en),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_mask   (wr_mask),
        .wr_dur_ns (wr_dur_ns),
        .start_in  (start_ns),
        .period_in (period_ns),
        .len_in    (list_len),
        .rd_idx    (rd_idx),
        .rd_mask   (rd_mask),
        .rd_dur    (rd_dur),
        .start_q   (start_q),
        .period_q  (period_q),
        .len_q     (len_q)
    );

    tas_sequencer #(
        .N_ENTRIES (N_ENTRIES),
        .N_TC      (N_TC),
        .TIME_W    (TIME_W),
        .DUR_W     (DUR_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .sched_en (sched_en),
        .now_ns   (now_ns),
        .start_q  (start_q),
        .period_q (period_q),
        .len_q    (len_q),
        .rd_idx   (rd_idx),
        .rd_mask  (rd_mask),
        .rd_dur   (rd_dur),
        .fire     (fire),
        .gates_q  (gate_open_o),
        .event_q  (gate_event_o),
        .idx_q    (entry_idx_o)
    );

    tas_slot_guard u_guard (
        .clk            (clk),
        .rst            (rst),
        .sched_en       (sched_en),
        .fire           (fire),
        .peer_slot_busy (peer_slot_busy),
        .conflict_q     (conflict_o)
    );

    // R8: disabling closes every gate from the next clock
    assert_disable_closes_R8: assert property (@(posedge clk) disable iff (rst)
        !sched_en |=> ((gate_open_o == '0) && !gate_event_o));

    // R6: a conflict only ever accompanies an own event
    assert_conflict_with_event_R6: assert property (@(posedge clk) disable iff (rst)
        conflict_o |-> gate_event_o);

    // R5: a strobe follows only when the schedule was enabled
    assert_event_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        gate_event_o |-> $past(sched_en));

endmodule

// File: tb/test_tas_gate_sched.sv
module test_tas_gate_sched;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] now_ns;
    logic        sched_en;
    logic [63:0] start_ns;
    logic [31:0] period_ns;
    logic [4:0]  list_len;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [7:0]  wr_mask;
    logic [31:0] wr_dur_ns;
    logic        peer_slot_busy;
    logic [7:0]  gate_open_o;
    logic        gate_event_o;
    logic [3:0]  entry_idx_o;
    logic        conflict_o;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tas_gate_sched i_tas_gate_sched (
        .clk            (clk),
        .rst            (rst),
        .now_ns         (now_ns),
        .sched_en       (sched_en),
        .start_ns       (start_ns),
        .period_ns      (period_ns),
        .list_len       (list_len),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_mask        (wr_mask),
        .wr_dur_ns      (wr_dur_ns),
        .peer_slot_busy (peer_slot_busy),
        .gate_open_o    (gate_open_o),
        .gate_event_o   (gate_event_o),
        .entry_idx_o    (entry_idx_o),
        .conflict_o     (conflict_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (now=%0d)", req, what, act, exp, now_ns);
        end
    endtask

    task automatic tick(input logic [63:0] t);
        @(negedge clk);
        now_ns = t;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [7:0] g,
                              input logic ev, input logic [3:0] idx);
        chk(req, "gates", 64'(gate_open_o), 64'(g));
        chk(req, "event", 64'(gate_event_o), 64'(ev));
        chk(req, "index", 64'(entry_idx_o), 64'(idx));
    endtask

    task automatic write_entry(input logic [3:0] idx, input logic [7:0] m,
                               input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_mask = m; wr_dur_ns = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // R9: reset state
    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        tick(0);
        expect_out("R9", 8'h00, 1'b0, 4'd0);
        chk("R9", "conflict", 64'(conflict_o), 64'd0);
    endtask

    // R1 R2 R3 R4 R5 R7 R8: two-entry schedule, frozen list, disable
    task automatic t_basic;
        write_entry(4'd0, 8'h80, 32'd300);   // rounds to 400
        write_entry(4'd1, 8'h7F, 32'd400);
        start_ns = 64'd10000; period_ns = 32'd1000; list_len = 5'd2;
        tick(0);
        sched_en = 1'b1;
        tick(9000);  expect_out("R2", 8'h00, 1'b0, 4'd0);
        tick(9980);  expect_out("R2", 8'h00, 1'b0, 4'd0);
        tick(10000); expect_out("R1", 8'h80, 1'b1, 4'd0);
        tick(10000); expect_out("R5", 8'h80, 1'b0, 4'd0);
        tick(10380); expect_out("R3", 8'h80, 1'b0, 4'd0);
        tick(10400); expect_out("R1", 8'h7F, 1'b1, 4'd1);
        tick(10980); expect_out("R4", 8'h7F, 1'b0, 4'd1);
        tick(11000); expect_out("R4", 8'h80, 1'b1, 4'd0);
        tick(11400); expect_out("R10", 8'h7F, 1'b1, 4'd1);
        // R7: writes and config changes while running
        write_entry(4'd0, 8'h01, 32'd200);
        start_ns = 64'd50000; period_ns = 32'd200; list_len = 5'd1;
        tick(11600); expect_out("R7", 8'h7F, 1'b0, 4'd1);
        tick(12000); expect_out("R7", 8'h80, 1'b1, 4'd0);
        tick(12200); expect_out("R7", 8'h80, 1'b0, 4'd0);
        tick(12400); expect_out("R7", 8'h7F, 1'b1, 4'd1);
        sched_en = 1'b0;
        tick(12500); expect_out("R8", 8'h00, 1'b0, 4'd0);
    endtask

    // R2 R3 R4 R6 R8: rounded start, zero duration, truncated entry, conflicts
    task automatic t_trunc_conflict;
        write_entry(4'd0, 8'h03, 32'd0);     // counts as 200
        write_entry(4'd1, 8'h0C, 32'd400);
        write_entry(4'd2, 8'h30, 32'd500);   // rounds to 600
        start_ns = 64'd20050;                // rounds to 20200
        period_ns = 32'd700;                 // rounds to 800
        list_len = 5'd3;
        tick(20000);
        sched_en = 1'b1;
        tick(20100); expect_out("R2", 8'h00, 1'b0, 4'd0);
        tick(20200); expect_out("R2", 8'h03, 1'b1, 4'd0);
        tick(20380); expect_out("R3", 8'h03, 1'b0, 4'd0);
        tick(20400); expect_out("R3", 8'h0C, 1'b1, 4'd1);
        tick(20780); expect_out("R1", 8'h0C, 1'b0, 4'd1);
        tick(20800); expect_out("R1", 8'h30, 1'b1, 4'd2);
        tick(21000); expect_out("R4", 8'h03, 1'b1, 4'd0);
        peer_slot_busy = 1'b1;
        tick(21100); chk("R6", "conflict_no_event", 64'(conflict_o), 64'd0);
        tick(21200); chk("R6", "conflict_on_event", 64'(conflict_o), 64'd1);
        expect_out("R6", 8'h0C, 1'b1, 4'd1);
        peer_slot_busy = 1'b0;
        tick(21600); chk("R6", "conflict_free_slot", 64'(conflict_o), 64'd0);
        expect_out("R6", 8'h30, 1'b1, 4'd2);
        sched_en = 1'b0;
        start_ns = 64'd30000;
        tick(29000); expect_out("R8", 8'h00, 1'b0, 4'd0);
        sched_en = 1'b1;
        tick(29800); expect_out("R8", 8'h00, 1'b0, 4'd0);
        tick(30000); expect_out("R8", 8'h03, 1'b1, 4'd0);
        sched_en = 1'b0;
        tick(30100);
    endtask

    initial begin
        rst = 1'b1; now_ns = '0; sched_en = 1'b0; start_ns = '0; period_ns = '0;
        list_len = '0; wr_en = 1'b0; wr_idx = '0; wr_mask = '0; wr_dur_ns = '0;
        peer_slot_busy = 1'b0;
        t_reset();
        t_basic();
        t_trunc_conflict();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule